// File: doc/BRIEF.md
# Stimulus Packet Validator and Latch

This block sits behind a pulse-width demodulator. Each demodulated bit comes with a one-cycle strobe and is shifted into a 16-bit window. After every shift, the window is examined as a whole. A packet is accepted only when all three of the following hold:

- the four oldest bits form an all-ones header;
- three fixed spacer positions hold zeros;
- an even-parity bit matches the XOR of the eight parameter bits.

On acceptance, the eight parameter bits are copied into a holding register that drives the stimulus controls, and a one-cycle trigger follows. The controls are two driver-select bits with their complements, a five-bit current level and a phase bit.

The window is cleared on every acceptance, so one packet fires exactly once. Reception continues while the held controls stay fixed, so the next packet can be sent during an ongoing stimulus.

Top module: `stim_pkt_latch`

## Requirements
- R1: A strobe on `bit_vld` shifts `bit_in` into the window. The first bit of a packet ends in window position 0 and the sixteenth in position 15.
- R2: A window is accepted only when positions 0, 1, 2 and 3 all hold 1.
- R3: A window is accepted only when positions 4, 8 and 12 all hold 0.
- R4: A window is accepted only when position 15 equals the XOR of positions 5, 6, 7, 9, 10, 11, 13 and 14.
- R5: On acceptance the held outputs update at the clock edge after the edge that captured the sixteenth bit. The field map is:
  - position 5 goes to `sel_a`;
  - position 6 goes to `sel_b`;
  - positions 7, 9, 10, 11 and 13 go to `level[0]` through `level[4]`, in that order;
  - position 14 goes to `phase`.
- R6: `stim_trig` is high for exactly one cycle. It rises one clock after the held outputs change.
- R7: A rejected window leaves every held output unchanged and produces no trigger.
- R8: An acceptance clears the window, so the same packet never triggers twice. A bit strobed in the same cycle as an acceptance is kept as the newest bit of the cleared window.
- R9: `sel_a_n` and `sel_b_n` are always the inverses of `sel_a` and `sel_b`.
- R10: While reset is asserted, all held outputs and `stim_trig` are 0, and the two complement outputs are 1.
- R11: While a new packet is being shifted in, the held outputs keep the values of the last accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_vld | input | 1 | One-cycle strobe marking a demodulated bit |
| bit_in | input | 1 | Demodulated bit value |
| sel_a | output | 1 | Held driver-select bit A |
| sel_a_n | output | 1 | Complement of `sel_a` |
| sel_b | output | 1 | Held driver-select bit B |
| sel_b_n | output | 1 | Complement of `sel_b` |
| level | output | 5 | Held current-level code |
| phase | output | 1 | Held phase bit |
| stim_trig | output | 1 | One-cycle stimulus trigger |

## Verification
The assertion that no acceptance follows another in back-to-back cycles assumes that only one bit can arrive per clock. A cleared window with a single new bit can then never show a header. The assertions also assume that `bit_vld` is a clean synchronous strobe.

The stimulus drives at most one bit per cycle and flushes each rejected packet with a following valid packet. It uses reject patterns whose shifted partial windows never contain four consecutive ones at the header positions. Under these conditions, every trigger the scoreboard sees must correspond to a packet it queued.

// File: rtl/stim_pkt_pkg.sv
package stim_pkt_pkg;

  localparam int PKT_W    = 16;
  localparam int CODE_W   = 5;
  localparam int PARAM_W  = 3 + CODE_W;

  // Window positions whose decoding the stimulus controls depend on.
  localparam int POS_SEL_A = 5;
  localparam int POS_SEL_B = 6;
  localparam int POS_LVL0  = 7;
  localparam int POS_LVL1  = 9;
  localparam int POS_LVL2  = 10;
  localparam int POS_LVL3  = 11;
  localparam int POS_LVL4  = 13;
  localparam int POS_PHASE = 14;
  localparam int POS_PAR   = 15;

  localparam logic [PKT_W-1:0] HDR_MASK = 16'h000F;
  localparam logic [PKT_W-1:0] SPC_MASK = 16'h1110;
  localparam logic [PKT_W-1:0] PAR_MASK = 16'h6EE0;

  typedef struct packed {
    logic              sel_a;
    logic              sel_b;
    logic [CODE_W-1:0] level;
    logic              phase;
  } stim_params_t;

endpackage

// File: rtl/pkt_shifter.sv
module pkt_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         clr,
  output logic [W-1:0] win
);

  logic [W-1:0] win_q;
  logic [W-1:0] win_d;

  // Next state: a clear wins over the old contents but keeps a bit
  // arriving in the same cycle as the newest entry.
  always_comb begin
    win_d = win_q;
    if (clr) begin
      win_d = '0;
      if (shift_en) win_d[W-1] = bit_in;
    end else if (shift_en) begin
      win_d = {bit_in, win_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win = win_q;

  // R8: window empty after a clear with no concurrent bit
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !shift_en |=> win_q == '0);

  // R8: a bit coincident with a clear survives alone at the top
  a_r8_clear_keeps_bit: assert property (@(posedge clk) disable iff (!rst_n)
    clr && shift_en |=> win_q[W-1] == $past(bit_in) && win_q[W-2:0] == '0);

  // R1: shifting moves older bits toward position 0
  a_r1_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !clr |=> win_q[W-2:0] == $past(win_q[W-1:1]));

  // R1: window holds when idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en && !clr |=> $stable(win_q));

endmodule

// File: rtl/pkt_checker.sv
module pkt_checker
  import stim_pkt_pkg::*;
(
  input  logic [PKT_W-1:0] win,
  output logic             accept,
  output stim_params_t     params
);

  logic [PKT_W-1:0] hdr_v;
  logic [PKT_W-1:0] spc_v;
  logic [PKT_W-1:0] par_v;

  for (genvar i = 0; i < PKT_W; i++) begin : g_pos
    if (HDR_MASK[i]) begin : g_hdr
      assign hdr_v[i] = win[i];
    end else begin : g_nohdr
      assign hdr_v[i] = 1'b1;
    end
    if (SPC_MASK[i]) begin : g_spc
      assign spc_v[i] = ~win[i];
    end else begin : g_nospc
      assign spc_v[i] = 1'b1;
    end
    if (PAR_MASK[i]) begin : g_par
      assign par_v[i] = win[i];
    end else begin : g_nopar
      assign par_v[i] = 1'b0;
    end
  end

  logic hdr_ok;
  logic spc_ok;
  logic par_ok;

  always_comb begin
    hdr_ok = &hdr_v;
    spc_ok = &spc_v;
    par_ok = (^par_v) == win[POS_PAR];
    accept = hdr_ok && spc_ok && par_ok;
  end

  always_comb begin
    params.sel_a    = win[POS_SEL_A];
    params.sel_b    = win[POS_SEL_B];
    params.level[0] = win[POS_LVL0];
    params.level[1] = win[POS_LVL1];
    params.level[2] = win[POS_LVL2];
    params.level[3] = win[POS_LVL3];
    params.level[4] = win[POS_LVL4];
    params.phase    = win[POS_PHASE];
  end

endmodule

// File: rtl/param_hold.sv
module param_hold
  import stim_pkt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  stim_params_t params_in,
  output stim_params_t params_out,
  output logic         trig
);

  stim_params_t par_q, par_d;
  logic         loaded_q, loaded_d;
  logic         trig_q, trig_d;

  always_comb begin
    par_d    = load_en ? params_in : par_q;
    loaded_d = load_en;
    trig_d   = loaded_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= '0;
      loaded_q <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      par_q    <= par_d;
      loaded_q <= loaded_d;
      trig_q   <= trig_d;
    end
  end

  assign params_out = par_q;
  assign trig       = trig_q;

  // R6: trigger lasts a single cycle
  a_r6_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);

  // R6: trigger comes two edges after the load request
  a_r6_trig_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> $past(load_en, 2));

  // R7: held parameters move only on a load
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(par_q));

endmodule

// File: rtl/stim_pkt_latch.sv
module stim_pkt_latch
  import stim_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              sel_a,
  output logic              sel_a_n,
  output logic              sel_b,
  output logic              sel_b_n,
  output logic [CODE_W-1:0] level,
  output logic              phase,
  output logic              stim_trig
);

  logic [PKT_W-1:0] win;
  logic             accept;
  stim_params_t     cand;
  stim_params_t     held;

  pkt_shifter #(.W(PKT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_vld),
    .bit_in   (bit_in),
    .clr      (accept),
    .win      (win)
  );

  pkt_checker u_check (
    .win    (win),
    .accept (accept),
    .params (cand)
  );

  param_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (accept),
    .params_in  (cand),
    .params_out (held),
    .trig       (stim_trig)
  );

  assign sel_a   = held.sel_a;
  assign sel_b   = held.sel_b;
  assign sel_a_n = ~held.sel_a;
  assign sel_b_n = ~held.sel_b;
  assign level   = held.level;
  assign phase   = held.phase;

  // R8: a cleared window cannot be accepted again on the next cycle
  a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  // R2: an accepted window always carries the header
  a_r2_header_seen: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> win[3:0] == 4'hF);

  // R3: an accepted window always carries clear spacers
  a_r3_spacers_seen: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !win[4] && !win[8] && !win[12]);

endmodule

// File: tb/stim_pkt_latch_tb_top.sv
`timescale 1ns/1ps
module stim_pkt_latch_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_vld;
  logic       bit_in;
  logic       sel_a, sel_a_n, sel_b, sel_b_n, phase, stim_trig;
  logic [4:0] level;

  always #2.5 clk = ~clk;

  stim_pkt_latch dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .sel_a     (sel_a),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_b_n   (sel_b_n),
    .level     (level),
    .phase     (phase),
    .stim_trig (stim_trig)
  );

  typedef struct {
    logic [7:0] exp;
    int         due;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int trig_seen = 0;
  bit done = 0;
  logic [7:0] prev_out;
  logic       prev_trig;

  always @(posedge clk) cyc++;

  function automatic logic [7:0] outs();
    return {sel_a, sel_b, level, phase};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Packet layout: header bits 0..3 = 1, spacers 4/8/12 = 0, S1 at 5, S2 at 6,
  // level bits at 7,9,10,11,13, phase at 14, parity at 15.
  function automatic logic [15:0] make_pkt(input logic s1, input logic s2,
                                           input logic [4:0] c, input logic ph);
    logic [15:0] p;
    p = 16'h000F;
    p[5] = s1; p[6] = s2; p[7] = c[0]; p[9] = c[1]; p[10] = c[2];
    p[11] = c[3]; p[13] = c[4]; p[14] = ph;
    p[15] = ^{s1, s2, c, ph};
    return p;
  endfunction

  // Driver: bit 0 goes first; a valid packet queues its expected item.
  task automatic send_pkt(input logic [15:0] p, input bit valid,
                          input bit do_mid, input logic [7:0] mid_exp);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (do_mid && i == 8)
        chk(outs() == mid_exp, "R11 held during reception", outs(), mid_exp);
      bit_vld = 1'b1;
      bit_in  = p[i];
      if (valid && i == 15) begin
        item_t it;
        it.exp = {p[5], p[6], p[13], p[11], p[10], p[9], p[7], p[14]};
        it.due = cyc + 3;
        q.push_back(it);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard on each trigger
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(sel_a_n == ~sel_a && sel_b_n == ~sel_b, "R9 complements",
          {sel_a_n, sel_b_n}, {~sel_a, ~sel_b});
      if (stim_trig) begin
        trig_seen++;
        chk(!prev_trig, "R6 single-cycle trigger", prev_trig, 0);
        if (q.size() == 0) begin
          chk(0, "R8/R7 unexpected trigger", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(outs() == it.exp, "R5 field map", outs(), it.exp);
          chk(prev_out == it.exp, "R6 outputs lead trigger by one cycle", prev_out, it.exp);
          chk(cyc == it.due, "R5 trigger latency", cyc, it.due);
        end
      end
    end
    prev_out  = outs();
    prev_trig = stim_trig;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [7:0] last;
  int         trig_before;

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(outs() == 8'h00 && !stim_trig, "R10 reset outputs", {outs(), stim_trig}, 0);
    chk(sel_a_n && sel_b_n, "R10 reset complements", {sel_a_n, sel_b_n}, 2'b11);
    rst_n = 1'b1;
    idle(2);

    // R1/R5: asymmetric fields expose ordering
    send_pkt(make_pkt(1'b1, 1'b0, 5'b10110, 1'b1), 1, 0, 0);
    idle(5);
    chk(sel_a_n == 1'b0 && sel_b_n == 1'b1, "R9 after load", {sel_a_n, sel_b_n}, 2'b01);

    // R8: back-to-back, the next first bit lands in the load cycle
    send_pkt(make_pkt(1'b0, 1'b1, 5'b01001, 1'b0), 1, 0, 0);
    send_pkt(make_pkt(1'b1, 1'b1, 5'b11111, 1'b0), 1, 1, {1'b0, 1'b1, 5'b01001, 1'b0});
    idle(5);
    last = {1'b1, 1'b1, 5'b11111, 1'b0};
    chk(outs() == last, "R8 back-to-back second packet", outs(), last);

    trig_before = trig_seen;
    // R2: broken header (bit 1 cleared)
    begin
      logic [15:0] p;
      p = make_pkt(1'b0, 1'b0, 5'b00000, 1'b0); p[1] = 1'b0;
      send_pkt(p, 0, 0, 0); idle(5);
      chk(outs() == last, "R2/R7 bad header ignored", outs(), last);
      // R3: spacer at bit 8 set
      p = make_pkt(1'b0, 1'b0, 5'b00000, 1'b0); p[8] = 1'b1;
      send_pkt(p, 0, 0, 0); idle(5);
      chk(outs() == last, "R3/R7 bad spacer ignored", outs(), last);
      // R4: parity flipped
      p = make_pkt(1'b1, 1'b0, 5'b00000, 1'b0); p[15] = ~p[15];
      send_pkt(p, 0, 0, 0); idle(5);
      chk(outs() == last, "R4/R7 bad parity ignored", outs(), last);
    end
    chk(trig_seen == trig_before, "R7 no trigger on rejects", trig_seen, trig_before);

    // R4: odd parameter count, parity 1
    send_pkt(make_pkt(1'b0, 1'b1, 5'b00001, 1'b1), 1, 0, 0);
    idle(20);
    chk(trig_seen == trig_before + 1, "R8 single trigger per packet", trig_seen, trig_before + 1);
    chk(q.size() == 0, "R5 all queued packets triggered", q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule